// File: doc/BRIEF.md
# Fingerprint Minutiae Matching Oracle

This block keeps an enrolled fingerprint template inside the chip and answers only three questions from software: clear the hit count, score one candidate minutia, and report whether enough hits have built up. A minutia is a point given as an x position, a y position and an angle in degrees. During enrollment, software writes the template slots and a master key. After that, no port returns either of them.

Commands arrive on a single valid/ready stream. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls for the whole of a compare. A sender that sees `cmd_ready` low may keep its command waiting, or it may withdraw it, and a withdrawn command leaves no trace. A compare visits every slot once, one slot per cycle, so its length does not depend on the candidate or on how many slots agree.

A query gives a one-cycle accept/reject pulse. One cycle later, it loads either the master key or a fixed decoy key onto the key output that feeds the cipher engine. Tolerances are plain control inputs and must stay steady while a compare runs.

Top module: `minu_oracle`

## Requirements
- R1: After reset, `cmd_ready` is 1, `busy` is 0, `res_valid` is 0, `key_load` is 0 and `key_out` equals the decoy key `BOGUS_KEY`.
- R2: A written slot agrees with the candidate when |dx| <= `tol_xy`, |dy| <= `tol_xy` and the angle distance <= `tol_ang`, all bounds inclusive. A slot never written since reset never agrees.
- R3: Angles lie in 0..359. The angle distance is the absolute difference d when d <= 180, and 360 - d otherwise, so 358 and 2 are 4 apart.
- R4: An accepted compare (`cmd_op` = 1) adds the number of agreeing slots to the hit counter. `busy` is high for exactly `SLOTS` cycles, starting in the cycle after acceptance, whatever the number of hits.
- R5: `cmd_ready` is the inverse of `busy`. A command offered while busy and withdrawn before `busy` falls has no effect.
- R6: An accepted init (`cmd_op` = 0) sets the hit counter to zero.
- R7: An accepted query (`cmd_op` = 2) raises `res_valid` for one cycle, in the cycle after acceptance. `res_accept` is 1 only if the counter is strictly greater than `MATCH_N`.
- R8: In the cycle after `res_valid`, `key_load` pulses for one cycle and `key_out` takes the master key on accept or `BOGUS_KEY` on reject. At all other times `key_out` holds its value.
- R9: Slot writes (`tmpl_we`) and master-key writes (`mkey_we`) take effect only while `enroll` is high. At other times they are ignored.
- R10: The hit counter saturates at 2^`CNT_W`-1 and never wraps to a small value.
- R11: Op code 3 is accepted but changes nothing: it produces no result pulse and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (not busy) |
| cmd_op | input | 2 | 0 init, 1 compare, 2 query, 3 no-op |
| cmd_x | input | 8 | Candidate x position |
| cmd_y | input | 8 | Candidate y position |
| cmd_ang | input | 9 | Candidate angle, 0..359 |
| busy | output | 1 | Compare in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Match decision, valid with res_valid |
| tol_xy | input | 8 | Position tolerance |
| tol_ang | input | 9 | Angle tolerance |
| enroll | input | 1 | Enrollment mode, enables writes |
| tmpl_we | input | 1 | Template slot write strobe |
| tmpl_idx | input | 5 | Slot index to write |
| tmpl_x | input | 8 | Slot x position |
| tmpl_y | input | 8 | Slot y position |
| tmpl_ang | input | 9 | Slot angle |
| mkey_we | input | 1 | Master key write strobe |
| mkey_data | input | 32 | Master key value |
| key_load | output | 1 | Key update strobe to the cipher engine |
| key_out | output | 32 | Selected key for the cipher engine |

## Verification
The hardest condition to reach from the ports is saturation. The counter is hidden, so wrapping can only be seen through the query result. The bench fills every slot with one point and scores that point twice, which gives 64 hits on a 6-bit counter: a wrapping counter would reject, while a saturating one accepts. The exact threshold boundary needs care too. Slots are written so that a candidate hits exactly `MATCH_N` and then `MATCH_N`+1 times. A command offered mid-compare is held for several busy cycles and then withdrawn, and a later query shows that the count survived. Constrained random rounds use clustered templates and perturbed candidates, so that hits near the tolerance edges are common.

// File: rtl/minu_pkg.sv
package minu_pkg;
  parameter int XY_W = 8;
  parameter int ANG_W = 9;
  localparam int ANG_FULL = 360;
  localparam int ANG_HALF = 180;

  typedef struct packed {
    logic [XY_W-1:0]  x;
    logic [XY_W-1:0]  y;
    logic [ANG_W-1:0] ang;
  } minutia_t;

  typedef enum logic [1:0] {
    OP_INIT  = 2'd0,
    OP_CMP   = 2'd1,
    OP_QUERY = 2'd2,
    OP_NONE  = 2'd3
  } op_e;
endpackage

// File: rtl/minu_store.sv
// Template slot storage: write-only from outside, one internal read port.
module minu_store
  import minu_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enroll,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  minutia_t         wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output minutia_t         rd_data,
  output logic             rd_valid
);
  minutia_t   mem [SLOTS];
  logic [SLOTS-1:0] vld;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic sel;
    assign sel = enroll && wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n)   vld[s] <= 1'b0;
      else if (sel) vld[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) mem[s] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_idx];
  assign rd_valid = vld[rd_idx];
endmodule

// File: rtl/minu_agree.sv
// Combinational agreement test between a candidate and one stored point.
module minu_agree
  import minu_pkg::*;
(
  input  minutia_t         cand,
  input  minutia_t         slot,
  input  logic [XY_W-1:0]  tol_xy,
  input  logic [ANG_W-1:0] tol_ang,
  output logic             hit
);
  logic [XY_W-1:0]  dx, dy;
  logic [ANG_W-1:0] da_raw, da;

  always_comb begin
    dx     = (cand.x >= slot.x) ? cand.x - slot.x : slot.x - cand.x;
    dy     = (cand.y >= slot.y) ? cand.y - slot.y : slot.y - cand.y;
    da_raw = (cand.ang >= slot.ang) ? cand.ang - slot.ang : slot.ang - cand.ang;
    // shorter way round the circle
    da     = (da_raw > ANG_W'(ANG_HALF)) ? ANG_W'(ANG_FULL) - da_raw : da_raw;
    hit    = (dx <= tol_xy) && (dy <= tol_xy) && (da <= tol_ang);
  end
endmodule

// File: rtl/minu_seq.sv
// Command sequencer: slot walk, saturating hit counter, threshold decision.
module minu_seq
  import minu_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int CNT_W   = 6,
  parameter int MATCH_N = 12,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  minutia_t         cmd_min,
  input  logic             slot_hit,
  output logic             cmd_ready,
  output logic             busy,
  output logic [IDX_W-1:0] slot_idx,
  output minutia_t         probe,
  output logic [CNT_W-1:0] cnt,
  output logic             res_valid,
  output logic             res_accept
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

  logic take;
  assign cmd_ready = !busy;
  assign take      = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      slot_idx   <= '0;
      probe      <= '0;
      cnt        <= '0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (busy) begin
        if (slot_hit && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
        if (slot_idx == IDX_LAST) begin
          busy     <= 1'b0;
          slot_idx <= '0;
        end else begin
          slot_idx <= slot_idx + IDX_W'(1);
        end
      end else if (take) begin
        case (op_e'(cmd_op))
          OP_INIT:  cnt <= '0;
          OP_CMP: begin
            probe    <= cmd_min;
            slot_idx <= '0;
            busy     <= 1'b1;
          end
          OP_QUERY: begin
            res_valid  <= 1'b1;
            res_accept <= (cnt > CNT_W'(MATCH_N));
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/minu_oracle.sv
module minu_oracle
  import minu_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int CNT_W   = 6,
  parameter int MATCH_N = 12,
  parameter int KEY_W   = 32,
  parameter logic [KEY_W-1:0] BOGUS_KEY = 32'h5A3C_96E1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic [XY_W-1:0]          cmd_x,
  input  logic [XY_W-1:0]          cmd_y,
  input  logic [ANG_W-1:0]         cmd_ang,
  output logic                     busy,
  output logic                     res_valid,
  output logic                     res_accept,
  input  logic [XY_W-1:0]          tol_xy,
  input  logic [ANG_W-1:0]         tol_ang,
  input  logic                     enroll,
  input  logic                     tmpl_we,
  input  logic [$clog2(SLOTS)-1:0] tmpl_idx,
  input  logic [XY_W-1:0]          tmpl_x,
  input  logic [XY_W-1:0]          tmpl_y,
  input  logic [ANG_W-1:0]         tmpl_ang,
  input  logic                     mkey_we,
  input  logic [KEY_W-1:0]         mkey_data,
  output logic                     key_load,
  output logic [KEY_W-1:0]         key_out
);
  localparam int IDX_W = $clog2(SLOTS);

  minutia_t         cmd_min, wr_min, probe, slot_rd;
  logic             slot_vld, agree_hit, slot_hit;
  logic [IDX_W-1:0] slot_idx;
  logic [CNT_W-1:0] hit_cnt;
  logic [KEY_W-1:0] mkey_q;

  assign cmd_min = '{x: cmd_x, y: cmd_y, ang: cmd_ang};
  assign wr_min  = '{x: tmpl_x, y: tmpl_y, ang: tmpl_ang};

  minu_store #(.SLOTS(SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .enroll(enroll), .wr_en(tmpl_we),
    .wr_idx(tmpl_idx), .wr_data(wr_min), .rd_idx(slot_idx),
    .rd_data(slot_rd), .rd_valid(slot_vld)
  );

  minu_agree u_agree (
    .cand(probe), .slot(slot_rd), .tol_xy(tol_xy), .tol_ang(tol_ang),
    .hit(agree_hit)
  );

  assign slot_hit = agree_hit && slot_vld;

  minu_seq #(.SLOTS(SLOTS), .CNT_W(CNT_W), .MATCH_N(MATCH_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_min(cmd_min), .slot_hit(slot_hit), .cmd_ready(cmd_ready),
    .busy(busy), .slot_idx(slot_idx), .probe(probe), .cnt(hit_cnt),
    .res_valid(res_valid), .res_accept(res_accept)
  );

  // master key: enrollment-only write, no read path
  always_ff @(posedge clk) begin
    if (!rst_n)                 mkey_q <= '0;
    else if (enroll && mkey_we) mkey_q <= mkey_data;
  end

  // key selection follows the decision by one cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_out  <= BOGUS_KEY;
      key_load <= 1'b0;
    end else begin
      key_load <= res_valid;
      if (res_valid) key_out <= res_accept ? mkey_q : BOGUS_KEY;
    end
  end
endmodule

// File: rtl/minu_oracle_chk.sv
module minu_oracle_chk #(
  parameter int SLOTS   = 32,
  parameter int CNT_W   = 6,
  parameter int MATCH_N = 12,
  parameter int KEY_W   = 32,
  parameter logic [KEY_W-1:0] BOGUS_KEY = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             busy,
  input logic             res_valid,
  input logic             res_accept,
  input logic [CNT_W-1:0] cnt,
  input logic             key_load,
  input logic [KEY_W-1:0] key_out,
  input logic [KEY_W-1:0] mkey
);
  localparam int RW = $clog2(SLOTS + 2) + 1;
  logic [RW-1:0] runlen;
  logic take;
  assign take = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    runlen <= '0;
    else if (busy) runlen <= runlen + RW'(1);
    else           runlen <= '0;
  end

  p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  p_fixed_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> runlen == RW'(SLOTS));

  p_init_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 2'd0 |=> cnt == '0);

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {CNT_W{1'b1}}) && !(take && cmd_op == 2'd0) |=> cnt == {CNT_W{1'b1}});

  p_query_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 2'd2 |=>
      res_valid && (res_accept == ($past(cnt) > CNT_W'(MATCH_N))));

  p_key_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> key_load &&
      (key_out == ($past(res_accept) ? $past(mkey) : BOGUS_KEY)));

  p_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 2'd3 |=> !res_valid && $stable(cnt));
endmodule

bind minu_oracle minu_oracle_chk #(
  .SLOTS(SLOTS), .CNT_W(CNT_W), .MATCH_N(MATCH_N), .KEY_W(KEY_W),
  .BOGUS_KEY(BOGUS_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .busy(busy), .res_valid(res_valid),
  .res_accept(res_accept), .cnt(hit_cnt), .key_load(key_load),
  .key_out(key_out), .mkey(mkey_q)
);

// File: tb/sim_minu_oracle.sv
module sim_minu_oracle;
  localparam int CLK_P = 10;
  localparam int SLOTS = 32;
  localparam int CNT_W = 6;
  localparam int MATCH_N = 12;
  localparam int KEY_W = 32;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam logic [KEY_W-1:0] BOGUS = 32'h5A3C_96E1;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_x = 0, cmd_y = 0, tol_xy = 0;
  logic [8:0] cmd_ang = 0, tol_ang = 0;
  logic busy, res_valid, res_accept, key_load;
  logic enroll = 0, tmpl_we = 0, mkey_we = 0;
  logic [4:0] tmpl_idx = 0;
  logic [7:0] tmpl_x = 0, tmpl_y = 0;
  logic [8:0] tmpl_ang = 0;
  logic [KEY_W-1:0] mkey_data = 0, key_out;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int mx[SLOTS], my[SLOTS], ma[SLOTS];
  bit mv[SLOTS];
  int mcnt = 0;
  logic [KEY_W-1:0] mkey_m = '0;

  always #(CLK_P/2) clk = ~clk;

  minu_oracle u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_ang(cmd_ang),
    .busy(busy), .res_valid(res_valid), .res_accept(res_accept),
    .tol_xy(tol_xy), .tol_ang(tol_ang), .enroll(enroll), .tmpl_we(tmpl_we),
    .tmpl_idx(tmpl_idx), .tmpl_x(tmpl_x), .tmpl_y(tmpl_y),
    .tmpl_ang(tmpl_ang), .mkey_we(mkey_we), .mkey_data(mkey_data),
    .key_load(key_load), .key_out(key_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit agree_m(input int cx, cy, ca, input int s);
    int da = iabs(ca - ma[s]);
    if (da > 180) da = 360 - da;
    return mv[s] && iabs(cx - mx[s]) <= int'(tol_xy) &&
           iabs(cy - my[s]) <= int'(tol_xy) && da <= int'(tol_ang);
  endfunction

  task automatic wr_slot(input int s, x, y, a);
    @(negedge clk);
    tmpl_we = 1; tmpl_idx = 5'(s); tmpl_x = 8'(x); tmpl_y = 8'(y); tmpl_ang = 9'(a);
    @(negedge clk);
    tmpl_we = 0;
    if (enroll) begin mx[s] = x; my[s] = y; ma[s] = a; mv[s] = 1; end
  endtask

  task automatic wr_key(input logic [KEY_W-1:0] k);
    @(negedge clk);
    mkey_we = 1; mkey_data = k;
    @(negedge clk);
    mkey_we = 0;
    if (enroll) mkey_m = k;
  endtask

  task automatic do_cmd(input int op, input int x, y, a);
    int h, n;
    logic [KEY_W-1:0] expk;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_x = 8'(x); cmd_y = 8'(y); cmd_ang = 9'(a);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    case (op)
      0: mcnt = 0; // R6
      1: begin
        h = 0;
        for (int s = 0; s < SLOTS; s++) if (agree_m(x, y, a, s)) h++;
        mcnt = (mcnt + h > CMAX) ? CMAX : mcnt + h; // R10 saturation
        n = 0;
        while (busy && n < 1000) begin
          check(!cmd_ready, "R5 ready low while busy", cmd_ready, 0);
          n++;
          @(negedge clk);
        end
        check(n == SLOTS, "R4 busy length", n, SLOTS);
      end
      2: begin
        check(res_valid == 1, "R7 result strobe", res_valid, 1);
        check(res_accept == (mcnt > MATCH_N), "R7 decision", res_accept, mcnt > MATCH_N);
        expk = (mcnt > MATCH_N) ? mkey_m : BOGUS;
        @(negedge clk);
        check(key_load == 1, "R8 key strobe", key_load, 1);
        check(key_out == expk, "R8 key value", key_out, expk);
        @(negedge clk);
        check(key_load == 0 && key_out == expk, "R8 key hold", key_out, expk);
      end
      default: check(res_valid == 0, "R11 no result for no-op", res_valid, 0);
    endcase
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < SLOTS; s++) mv[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cmd_ready == 1 && busy == 0, "R1 idle after reset", {cmd_ready, busy}, 2'b10);
    check(res_valid == 0 && key_load == 0, "R1 no strobes", {res_valid, key_load}, 0);
    check(key_out == BOGUS, "R1 decoy key", key_out, BOGUS);

    // unwritten slots never agree (R2)
    tol_xy = 255; tol_ang = 180;
    do_cmd(0, 0, 0, 0);
    do_cmd(1, 10, 10, 10);
    do_cmd(2, 0, 0, 0);

    // enrollment: 12 matching slots, rest far (R7 boundary)
    enroll = 1;
    wr_key(32'hC0DE_1234);
    for (int s = 0; s < SLOTS; s++)
      if (s < MATCH_N) wr_slot(s, 50, 50, 100); else wr_slot(s, 200, 10, 300);
    tol_xy = 0; tol_ang = 0;
    do_cmd(0, 0, 0, 0);
    do_cmd(1, 50, 50, 100);         // exactly MATCH_N hits -> reject (R7)
    do_cmd(2, 0, 0, 0);
    wr_slot(MATCH_N, 50, 50, 100);
    do_cmd(0, 0, 0, 0);
    do_cmd(1, 50, 50, 100);         // MATCH_N+1 -> accept
    do_cmd(2, 0, 0, 0);

    // R2 tolerance edges
    tol_xy = 3;
    do_cmd(0, 0, 0, 0); do_cmd(1, 53, 47, 100); do_cmd(2, 0, 0, 0);
    tol_xy = 2;
    do_cmd(0, 0, 0, 0); do_cmd(1, 53, 50, 100); do_cmd(2, 0, 0, 0);

    // R3 angle wrap around 0/360
    for (int s = 0; s <= MATCH_N; s++) wr_slot(s, 50, 50, 358);
    tol_xy = 0; tol_ang = 5;
    do_cmd(0, 0, 0, 0); do_cmd(1, 50, 50, 2); do_cmd(2, 0, 0, 0);
    tol_ang = 3;
    do_cmd(0, 0, 0, 0); do_cmd(1, 50, 50, 2); do_cmd(2, 0, 0, 0);

    // R5 init offered while busy and withdrawn: count must survive
    tol_ang = 5;
    do_cmd(0, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd1; cmd_x = 50; cmd_y = 50; cmd_ang = 2;
    @(negedge clk);
    cmd_op = 2'd0;                  // compare taken; now offer init
    repeat (4) begin
      check(busy && !cmd_ready, "R5 init refused while busy", cmd_ready, 0);
      @(negedge clk);
    end
    cmd_valid = 0;
    mcnt = MATCH_N + 1;
    while (busy) @(negedge clk);
    do_cmd(2, 0, 0, 0);             // still accept

    // R11 no-op keeps count and gives no result
    do_cmd(3, 0, 0, 0);
    do_cmd(2, 0, 0, 0);

    // R9 writes outside enrollment ignored
    enroll = 0;
    wr_key(32'hDEAD_0000);
    for (int s = 0; s <= MATCH_N; s++) wr_slot(s, 1, 1, 1);
    do_cmd(0, 0, 0, 0); do_cmd(1, 50, 50, 2); do_cmd(2, 0, 0, 0);
    check(key_out == 32'hC0DE_1234, "R9 master key unchanged", key_out, 32'hC0DE_1234);

    // R10 saturation: 32 hits twice = 64 > 63
    enroll = 1;
    for (int s = 0; s < SLOTS; s++) wr_slot(s, 9, 9, 9);
    tol_xy = 0; tol_ang = 0;
    do_cmd(0, 0, 0, 0);
    do_cmd(1, 9, 9, 9);
    do_cmd(1, 9, 9, 9);
    check(mcnt == CMAX, "R10 model saturated", mcnt, CMAX);
    do_cmd(2, 0, 0, 0);             // wrap would reject
    do_cmd(1, 200, 200, 200);       // zero hits, same length (R4)
    do_cmd(2, 0, 0, 0);

    // constrained random rounds
    for (int r = 0; r < 12; r++) begin
      enroll = 1;
      wr_key($urandom);
      for (int s = 0; s < SLOTS; s++)
        wr_slot(s, 100 + $urandom % 24, 100 + $urandom % 24, $urandom % 360);
      enroll = 0;
      tol_xy = 8'($urandom % 12);
      tol_ang = 9'($urandom % 40);
      do_cmd(0, 0, 0, 0);
      for (int c = 0; c < 4; c++) begin
        int s = $urandom % SLOTS;
        int cx = mx[s] + int'($urandom % 9) - 4;
        int cy = my[s] + int'($urandom % 9) - 4;
        int ca = (ma[s] + int'($urandom % 21) + 350) % 360;
        do_cmd(1, cx, cy, ca);
      end
      do_cmd(2, 0, 0, 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule